// File: doc/BRIEF.md
# Single-Level Interrupt Entry Controller

This block decides when a small processor with one maskable interrupt leaves its normal instruction stream. Each cycle it looks at a level-sensitive request line and a global enable bit. When both are high it issues a one-cycle redirect of instruction fetch to a fixed vector address, stores the address of the instruction that would have run next, and clears the global enable bit, so the same request cannot be taken again while the handler runs.

A return strobe from the decoder redirects fetch back to the stored address and sets the global enable bit again. Both happen in the same cycle. After entry the block keeps no "inside the handler" state. A return behaves the same whether or not an entry came before it. Foreground software may also write the enable bit directly. The request source is cleared by software, never by this block.

Top module: `irq_entry_ctrl`

## Requirements
- R1: An entry redirect (`redirect_o` high while `ret_req_i` is low) occurs in a cycle only when `irq_req_i` and `gie_o` are both high in that cycle. The output is combinational, with no added latency.
- R2: The target of an entry redirect is the parameter `VECTOR_ADDR` (default 4).
- R3: After an entry, `gie_o` is low from the next cycle on. A request held high then produces no further redirect until the bit is set again.
- R4: At the entry edge, `ret_addr_o` takes the value of `pc_i` from the entry cycle. Every later entry overwrites it.
- R5: While `ret_req_i` is high, `redirect_o` is high in the same cycle with `target_o` equal to `ret_addr_o`, and `gie_o` is high from the next cycle.
- R6: A return issued with no entry before it behaves exactly like any other return: it targets the current `ret_addr_o` and sets `gie_o`.
- R7: When `en_wr_i` is high with no entry and no return in that cycle, `gie_o` takes `en_wdata_i` from the next cycle. Running with `gie_o` low produces no other change.
- R8: If an entry and a software write to the enable bit fall in the same cycle, the hardware clear wins and `gie_o` is low next cycle.
- R9: If `ret_req_i` is high in a cycle where an entry would otherwise occur, the return wins: the target is `ret_addr_o`, `ret_addr_o` does not change, and `gie_o` is high next cycle. A request still pending then enters one cycle later.
- R10: While `rst_n` is low, `gie_o` is 0, `ret_addr_o` is 0 and `redirect_o` is 0, even if `ret_req_i` is high.
- R11: A return and a software write in the same cycle leave `gie_o` high next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Level-sensitive interrupt request |
| pc_i | input | ADDR_W | Address of the instruction that would execute next |
| ret_req_i | input | 1 | Return-from-interrupt strobe |
| en_wr_i | input | 1 | Software write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| redirect_o | output | 1 | Redirect fetch in this cycle |
| target_o | output | ADDR_W | Fetch target while redirect_o is high |
| ret_addr_o | output | ADDR_W | Stored return address |
| gie_o | output | 1 | Current global enable bit |

## Verification
A wrong enable bit appears in the first cycle that has a pending request. In that cycle the redirect is either missing or repeated, so a scoreboard that compares every cycle catches it at once. A wrong stored return address stays hidden until the next return, where it appears as a wrong `target_o`. For that reason the bench issues returns both right after entries and with no entry before them. The collisions between entry, return and software write are each driven in one cycle, and the enable bit is checked in the following cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_ENTRY  = 2'd1,
      SRC_RETURN = 2'd2
   } redir_src_e;

endpackage

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
   import irq_entry_pkg::*;
(
   input  logic       live_i,
   input  logic       req_i,
   input  logic       gie_i,
   input  logic       ret_i,
   output redir_src_e src_o
);

   always_comb begin
      src_o = SRC_NONE;
      if (live_i) begin
         if (ret_i)              src_o = SRC_RETURN;
         else if (req_i && gie_i) src_o = SRC_ENTRY;
      end
   end

endmodule

// File: rtl/irq_gie_reg.sv
module irq_gie_reg
   import irq_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  redir_src_e src_i,
   input  logic       wr_en_i,
   input  logic       wr_data_i,
   output logic       gie_o
);

   logic gie_q;
   logic gie_d;

   always_comb begin
      gie_d = gie_q;
      unique case (src_i)
         SRC_ENTRY:  gie_d = 1'b0;
         SRC_RETURN: gie_d = 1'b1;
         default:    if (wr_en_i) gie_d = wr_data_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gie_q <= 1'b0;
      else        gie_q <= gie_d;
   end

   assign gie_o = gie_q;

   p_clear_after_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == SRC_ENTRY) |=> !gie_o);

   p_set_after_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == SRC_RETURN) |=> gie_o);

   p_sw_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && src_i == SRC_NONE) |=> gie_o == $past(wr_data_i));

endmodule

// File: rtl/irq_ret_reg.sv
module irq_ret_reg #(
   parameter int unsigned ADDR_W    = 16,
   parameter bit          USE_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

   logic [ADDR_W-1:0] addr_q;

   generate
      if (USE_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      addr_q <= ZERO_ADDR;
            else if (load_i) addr_q <= addr_i;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (load_i) addr_q <= addr_i;
         end
      end
   endgenerate

   assign addr_o = addr_q;

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> addr_o == $past(addr_i));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o));

endmodule

// File: rtl/irq_redirect_mux.sv
module irq_redirect_mux
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned VECTOR_ADDR = 4
) (
   input  redir_src_e        src_i,
   input  logic [ADDR_W-1:0] ret_addr_i,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] target_o
);

   localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VECTOR_ADDR);

   always_comb begin
      redirect_o = (src_i != SRC_NONE);
      target_o   = (src_i == SRC_RETURN) ? ret_addr_i : VEC;
   end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned VECTOR_ADDR = 4,
   parameter bit          RET_RESET   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              ret_req_i,
   input  logic              en_wr_i,
   input  logic              en_wdata_i,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] target_o,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic              gie_o
);

   generate
      if (ADDR_W < 3 || ADDR_W > 31) begin : g_bad_width
         $error("irq_entry_ctrl: ADDR_W must be within 3..31");
      end else if (VECTOR_ADDR >= (1 << ADDR_W)) begin : g_bad_vec
         $error("irq_entry_ctrl: VECTOR_ADDR does not fit in ADDR_W");
      end
   endgenerate

   redir_src_e src;
   logic       gie;
   logic       load_ret;

   irq_accept_arb u_arb (
      .live_i (rst_n),
      .req_i  (irq_req_i),
      .gie_i  (gie),
      .ret_i  (ret_req_i),
      .src_o  (src)
   );

   irq_gie_reg u_gie (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .wr_en_i   (en_wr_i),
      .wr_data_i (en_wdata_i),
      .gie_o     (gie)
   );

   assign load_ret = (src == SRC_ENTRY);

   irq_ret_reg #(
      .ADDR_W    (ADDR_W),
      .USE_RESET (RET_RESET)
   ) u_ret (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_ret),
      .addr_i (pc_i),
      .addr_o (ret_addr_o)
   );

   irq_redirect_mux #(
      .ADDR_W      (ADDR_W),
      .VECTOR_ADDR (VECTOR_ADDR)
   ) u_mux (
      .src_i      (src),
      .ret_addr_i (ret_addr_o),
      .redirect_o (redirect_o),
      .target_o   (target_o)
   );

   assign gie_o = gie;

   p_no_entry_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_req_i && !gie_o) |-> !redirect_o);

   p_vector_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !ret_req_i) |-> target_o == ADDR_W'(VECTOR_ADDR));

   p_entry_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !ret_req_i) |=> (!redirect_o || ret_req_i));

   p_return_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ret_req_i |-> (redirect_o && target_o == ret_addr_o));

   p_hw_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr_i && irq_req_i && gie_o && !ret_req_i) |=> !gie_o);

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |-> (!redirect_o && !gie_o));

endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/1ps
module test_irq_entry_ctrl;

   localparam int AW  = 16;
   localparam int VEC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_req_i = 1'b0;
   logic [AW-1:0] pc_i = '0;
   logic          ret_req_i = 1'b0;
   logic          en_wr_i = 1'b0;
   logic          en_wdata_i = 1'b0;
   logic          redirect_o;
   logic [AW-1:0] target_o;
   logic [AW-1:0] ret_addr_o;
   logic          gie_o;

   always #2.5 clk = ~clk;

   irq_entry_ctrl #(.ADDR_W(AW), .VECTOR_ADDR(VEC)) i_irq_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .pc_i(pc_i),
      .ret_req_i(ret_req_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
      .redirect_o(redirect_o), .target_o(target_o),
      .ret_addr_o(ret_addr_o), .gie_o(gie_o)
   );

   typedef struct {
      logic          redir;
      logic [AW-1:0] tgt;
      logic [AW-1:0] ret;
      logic          gie;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   logic          m_gie = 1'b0;
   logic [AW-1:0] m_ret = '0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic req, input logic [AW-1:0] pc,
                       input logic ret, input logic wr, input logic wd,
                       input string tag);
      exp_t e;
      logic acc;
      @(negedge clk);
      irq_req_i = req; pc_i = pc; ret_req_i = ret; en_wr_i = wr; en_wdata_i = wd;
      acc = req && m_gie && !ret;
      e.redir = acc || ret;
      e.tgt   = ret ? m_ret : AW'(VEC);
      e.ret   = m_ret;
      e.gie   = m_gie;
      e.tag   = tag;
      #1 q.push_back(e);
      if (acc) begin
         m_gie = 1'b0;
         m_ret = pc;
      end else if (ret) m_gie = 1'b1;
      else if (wr)      m_gie = wd;
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #2;
         if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            check(redirect_o === e.redir, e.tag, "redirect", int'(redirect_o), int'(e.redir));
            if (e.redir)
               check(target_o === e.tgt, e.tag, "target", int'(target_o), int'(e.tgt));
            check(ret_addr_o === e.ret, e.tag, "ret_addr", int'(ret_addr_o), int'(e.ret));
            check(gie_o === e.gie, e.tag, "gie", int'(gie_o), int'(e.gie));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      // R10: reset state, with a return strobe held during reset
      ret_req_i = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      check(redirect_o === 1'b0, "R10", "redirect", int'(redirect_o), 0);
      check(gie_o === 1'b0, "R10", "gie", int'(gie_o), 0);
      check(ret_addr_o === '0, "R10", "ret_addr", int'(ret_addr_o), 0);
      @(negedge clk);
      ret_req_i = 1'b0;
      rst_n = 1'b1;

      // R1: pending request with enable low gives no redirect
      step(1, 16'h0040, 0, 0, 0, "R1");
      step(1, 16'h0041, 0, 0, 0, "R1");
      // R7: software enables, request low
      step(0, 16'h0042, 0, 1, 1, "R7");
      // R1 R2 R4: entry
      step(1, 16'h0100, 0, 0, 0, "R2");
      // R3: held request, no second entry
      step(1, 16'h0004, 0, 0, 0, "R3");
      step(1, 16'h0005, 0, 0, 0, "R3");
      // R5: return
      step(0, 16'h0006, 1, 0, 0, "R5");
      step(0, 16'h0100, 0, 0, 0, "R5");
      // R6: return with no prior entry
      step(0, 16'h0101, 1, 0, 0, "R6");
      step(0, 16'h0102, 0, 0, 0, "R6");
      // R7: foreground write 0 then 1
      step(1, 16'h0103, 0, 1, 0, "R7");
      step(1, 16'h0104, 0, 0, 0, "R7");
      step(0, 16'h0105, 0, 1, 1, "R7");
      // R8: entry and write 1 collide
      step(1, 16'h0200, 0, 1, 1, "R8");
      step(0, 16'h0004, 0, 0, 0, "R8");
      // R4: return then second entry overwrites
      step(0, 16'h0005, 1, 0, 0, "R4");
      step(1, 16'h0300, 0, 0, 0, "R4");
      step(0, 16'h0004, 0, 0, 0, "R4");
      // R9: return while an entry would fire
      step(0, 16'h0005, 1, 0, 0, "R9");
      step(1, 16'h0777, 1, 0, 0, "R9");
      step(1, 16'h0310, 0, 0, 0, "R9");
      step(0, 16'h0004, 0, 0, 0, "R9");
      // R11: return and write 0 collide
      step(0, 16'h0005, 1, 1, 0, "R11");
      step(0, 16'h0310, 0, 0, 0, "R11");
      // R1: entry after re-enable, request low afterwards
      step(1, 16'h0abc, 0, 0, 0, "R1");
      step(0, 16'h0004, 0, 0, 0, "R1");
      step(0, 16'h0005, 0, 0, 0, "R3");

      @(negedge clk);
      irq_req_i = 1'b0; ret_req_i = 1'b0; en_wr_i = 1'b0;
      repeat (2) @(negedge clk);
      #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule